// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Hours Field

This block keeps the time of day and the calendar for a real-time clock. Seconds, minutes, hours, date, weekday, month and a two-digit year are held as packed BCD registers. All of them advance from a one-cycle 1 Hz tick strobe whenever the run control is high. A carry passes from seconds up to years. The date wraps according to the length of the month, and February gets a 29th day in years divisible by four.

The hours register carries its own format bit. In 24-hour mode a second bit of that register is the tens digit value 2. In 12-hour mode the same bit marks PM. The rollover rules follow the format. The host sets any field through a single-field write port. A write lands on the next clock edge, and a tick that arrives in a write cycle is dropped. Every field is presented in parallel for readback and for an external alarm comparator. The only reset is the power-on reset `rst_ni`. The block has no other reset input, so a logic-level restart elsewhere in the chip leaves the time untouched.

Top module: `bcd_calendar`

## Requirements
- R1: After `rst_ni` is asserted, the fields read seconds 00, minutes 00, hours 0x00 (24-hour mode), date 01, weekday 01, month 01 and year 00.
- R2: Seconds and minutes count 00 to 59 in BCD, with the tens digit in bits 6:4 and the ones digit in bits 3:0. Each wraps to 00 and carries into the next field. Counting happens only on a clock edge where `tick_i` and `run_i` are both 1 and no write is made.
- R3: While `run_i` is 0, ticks are ignored and every field holds its value.
- R4: The hours layout is: bit 6 is the format (1 = 12-hour, 0 = 24-hour), bit 5 is the tens value 2 in 24-hour mode or PM in 12-hour mode, bit 4 is the tens value 1, and bits 3:0 are the ones digit. Bit 7 always reads 0. The format bit changes only through a write.
- R5: In 24-hour mode the hours run 00 to 23, then wrap to 00 and advance the date and weekday.
- R6: In 12-hour mode the hours run 12, 01, ..., 11. The step from 11 to 12 toggles PM. Only the step from 11 PM to 12 AM advances the date.
- R7: The date wraps to 01 and advances the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12. It does so after day 30 in months 04, 06, 09 and 11, and after day 28 in February of a common year.
- R8: A year whose BCD value is divisible by 4 (00 included) is a leap year, and its February wraps after day 29.
- R9: The weekday counts 1 to 7 in bits 2:0, advances with every date step, and wraps from 7 to 1.
- R10: The month counts 01 to 12 and advances the year when it wraps. The year counts 00 to 99 and wraps from 99 to 00.
- R11: `wr_sel_i` selects the field to write: 0 seconds, 1 minutes, 2 hours, 3 date, 4 weekday, 5 month, 6 year, 7 none. The written value, masked to the field's bits, is visible one clock later. A tick in a write cycle is discarded for all fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | 1 Hz strobe, one clock wide |
| run_i | input | 1 | Counting enable |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | BCD value to write |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with format and PM/tens bits |
| date_o | output | 8 | Day of month |
| wday_o | output | 8 | Weekday |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
Every field is a register. A tick or write sampled at one rising edge therefore shows its full effect, including a carry through all seven fields, right after that edge, with no further latency. The bench drives each tick and write on a falling edge, holds it across one rising edge, and compares the outputs at the following falling edge. Each result is read exactly one cycle after its stimulus. Scenarios preload a field just below its wrap point with writes, which take one cycle each, and then issue one tick. This makes the carry chain's month, leap-year and 12/24-hour corners show up within a single cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FIELD_W = 8;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DATE = 3'd3,
    F_WDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_NONE = 3'd7
  } field_e;

  function automatic logic [FIELD_W-1:0] bcd_inc(logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/cal_wrap_ctr.sv
module cal_wrap_ctr
  import cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] LO   = 8'h00,
  parameter logic [FIELD_W-1:0] RST  = 8'h00,
  parameter logic [FIELD_W-1:0] MASK = 8'hFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic [FIELD_W-1:0] hi_i,
  output logic [FIELD_W-1:0] val_o,
  output logic               carry_o
);
  logic [FIELD_W-1:0] val_q, val_d;
  logic               at_top;

  assign at_top  = (val_q >= hi_i);
  assign carry_o = step_i & at_top;

  always_comb begin
    val_d = val_q;
    if (wr_i)        val_d = wr_data_i & MASK;
    else if (step_i) val_d = at_top ? LO : bcd_inc(val_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= RST;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/cal_hour_ctr.sv
module cal_hour_ctr
  import cal_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               wr_i,
  input  logic [6:0]         wr_data_i,
  output logic [FIELD_W-1:0] hour_o,
  output logic               carry_o
);
  // q[6]=12h mode, q[5]=PM or tens-2, q[4]=tens-1, q[3:0]=ones
  logic [6:0] q, d;
  logic [FIELD_W-1:0] inc24, inc12;
  logic mode12, pm;

  assign mode12 = q[6];
  assign pm     = q[5];
  assign inc24  = bcd_inc({2'b00, q[5:0]});
  assign inc12  = bcd_inc({3'b000, q[4:0]});

  always_comb begin
    d       = q;
    carry_o = 1'b0;
    if (wr_i) begin
      d = wr_data_i;
    end else if (step_i) begin
      if (mode12) begin
        if (q[4:0] == 5'h11) begin
          d[5]    = ~pm;
          d[4:0]  = 5'h12;
          carry_o = pm;           // 11 PM -> 12 AM ends the day
        end else if (q[4:0] >= 5'h12) begin
          d[4:0]  = 5'h01;
        end else begin
          d[4:0]  = inc12[4:0];
        end
      end else begin
        if (q[5:0] >= 6'h23) begin
          d[5:0]  = 6'h00;
          carry_o = 1'b1;
        end else begin
          d[5:0]  = inc24[5:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 7'h00;
    else         q <= d;
  end

  assign hour_o = {1'b0, q};
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [4:0]         mon_i,
  input  logic               yr_tens_odd_i,
  input  logic [1:0]         yr_ones_lo_i,
  output logic [FIELD_W-1:0] last_day_o
);
  logic leap;

  // tens even: ones in {0,4,8}; tens odd: ones in {2,6}
  assign leap = (yr_ones_lo_i == {yr_tens_odd_i, 1'b0});

  always_comb begin
    unique case (mon_i)
      5'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] date_o,
  output logic [FIELD_W-1:0] wday_o,
  output logic [FIELD_W-1:0] mon_o,
  output logic [FIELD_W-1:0] year_o
);
  logic tick_step;
  logic sec_c, min_c, hour_c, date_c, mon_c;
  logic unused_carry_wday, unused_carry_year;
  logic [FIELD_W-1:0] last_day;

  assign tick_step = tick_i & run_i & ~wr_en_i;

  function automatic logic wr_hit(field_e f);
    return wr_en_i && (wr_sel_i == f);
  endfunction

  cal_wrap_ctr #(.LO(8'h00), .RST(8'h00), .MASK(8'h7F)) u_sec (
    .clk_i, .rst_ni, .step_i(tick_step), .wr_i(wr_hit(F_SEC)), .wr_data_i,
    .hi_i(8'h59), .val_o(sec_o), .carry_o(sec_c));

  cal_wrap_ctr #(.LO(8'h00), .RST(8'h00), .MASK(8'h7F)) u_min (
    .clk_i, .rst_ni, .step_i(sec_c), .wr_i(wr_hit(F_MIN)), .wr_data_i,
    .hi_i(8'h59), .val_o(min_o), .carry_o(min_c));

  cal_hour_ctr u_hour (
    .clk_i, .rst_ni, .step_i(min_c), .wr_i(wr_hit(F_HOUR)),
    .wr_data_i(wr_data_i[6:0]), .hour_o, .carry_o(hour_c));

  cal_month_len u_mlen (
    .mon_i(mon_o[4:0]), .yr_tens_odd_i(year_o[4]), .yr_ones_lo_i(year_o[1:0]),
    .last_day_o(last_day));

  cal_wrap_ctr #(.LO(8'h01), .RST(8'h01), .MASK(8'h3F)) u_date (
    .clk_i, .rst_ni, .step_i(hour_c), .wr_i(wr_hit(F_DATE)), .wr_data_i,
    .hi_i(last_day), .val_o(date_o), .carry_o(date_c));

  cal_wrap_ctr #(.LO(8'h01), .RST(8'h01), .MASK(8'h07)) u_wday (
    .clk_i, .rst_ni, .step_i(hour_c), .wr_i(wr_hit(F_WDAY)), .wr_data_i,
    .hi_i(8'h07), .val_o(wday_o), .carry_o(unused_carry_wday));

  cal_wrap_ctr #(.LO(8'h01), .RST(8'h01), .MASK(8'h1F)) u_mon (
    .clk_i, .rst_ni, .step_i(date_c), .wr_i(wr_hit(F_MON)), .wr_data_i,
    .hi_i(8'h12), .val_o(mon_o), .carry_o(mon_c));

  cal_wrap_ctr #(.LO(8'h00), .RST(8'h00), .MASK(8'hFF)) u_year (
    .clk_i, .rst_ni, .step_i(mon_c), .wr_i(wr_hit(F_YEAR)), .wr_data_i,
    .hi_i(8'h99), .val_o(year_o), .carry_o(unused_carry_year));
endmodule

// File: rtl/bcd_calendar_sva.sv
module bcd_calendar_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       run_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] wday_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o
);
  logic adv, end_hour;
  assign adv      = tick_i && run_i && !wr_en_i;
  assign end_hour = adv && (min_o == 8'h59) && (sec_o == 8'h59);

  AST_RUN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable({sec_o, min_o, hour_o, date_o, wday_o, mon_o, year_o})); // R3

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sec_o == 8'h59) |=> (sec_o == 8'h00)); // R2

  AST_WRITE_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == ($past(wr_data_i) & 8'h7F))); // R11

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(hour_o[6])); // R4

  AST_WRAP_24H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_hour && hour_o == 8'h23) |=> (hour_o == 8'h00 && date_o != $past(date_o))); // R5

  AST_PM_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_hour && hour_o[6] && hour_o[4:0] == 5'h11) |=> (hour_o[5] != $past(hour_o[5]))); // R6
endmodule

bind bcd_calendar bcd_calendar_sva u_sva (.*);

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_tb_top;
  localparam logic [2:0] S_SEC = 3'd0, S_MIN = 3'd1, S_HOUR = 3'd2, S_DATE = 3'd3,
                         S_WDAY = 3'd4, S_MON = 3'd5, S_YEAR = 3'd6, S_NONE = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec, min, hour, date, wday, mon, year;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bcd_calendar dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .sec_o(sec), .min_o(min), .hour_o(hour),
    .date_o(date), .wday_o(wday), .mon_o(mon), .year_o(year));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] v);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, m, s, d, wd, mo, y);
    wr(S_HOUR, h); wr(S_MIN, m); wr(S_SEC, s);
    wr(S_DATE, d); wr(S_WDAY, wd); wr(S_MON, mo); wr(S_YEAR, y);
  endtask

  task automatic t_reset();
    chk("R1 sec", sec, 8'h00);  chk("R1 min", min, 8'h00);
    chk("R1 hour", hour, 8'h00); chk("R1 date", date, 8'h01);
    chk("R1 wday", wday, 8'h01); chk("R1 mon", mon, 8'h01);
    chk("R1 year", year, 8'h00);
  endtask

  task automatic t_sec_min();
    set_all(8'h05, 8'h00, 8'h58, 8'h10, 8'h02, 8'h06, 8'h30);
    tick1(); chk("R2 sec 58->59", sec, 8'h59);
    tick1(); chk("R2 sec wrap", sec, 8'h00); chk("R2 min carry", min, 8'h01);
    wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
    tick1(); chk("R2 min wrap", min, 8'h00); chk("R2 hour carry", hour, 8'h06);
    chk("R2 date held", date, 8'h10);
  endtask

  task automatic t_run_off();
    wr(S_SEC, 8'h21);
    run = 1'b0;
    for (int i = 0; i < 3; i++) tick1();
    chk("R3 sec held", sec, 8'h21); chk("R3 min held", min, 8'h00);
    run = 1'b1;
    tick1(); chk("R3 resumes", sec, 8'h22);
  endtask

  task automatic t_24h();
    set_all(8'h19, 8'h59, 8'h59, 8'h05, 8'h02, 8'h03, 8'h30);
    tick1(); chk("R5 19->20", hour, 8'h20); chk("R5 no date step", date, 8'h05);
    wr(S_HOUR, 8'h23); wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
    tick1(); chk("R5 23->00", hour, 8'h00); chk("R5 date step", date, 8'h06);
    chk("R9 wday step", wday, 8'h03);
  endtask

  task automatic t_12h();
    set_all(8'h51, 8'h59, 8'h59, 8'h14, 8'h04, 8'h07, 8'h30);
    tick1(); chk("R6 11AM->12PM", hour, 8'h72); chk("R6 no date at noon", date, 8'h14);
    wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
    tick1(); chk("R6 12PM->01PM", hour, 8'h61);
    wr(S_HOUR, 8'h71); wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
    tick1(); chk("R6 11PM->12AM", hour, 8'h52); chk("R6 date at midnight", date, 8'h15);
    chk("R4 mode kept", {7'd0, hour[6]}, 8'h01);
    wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
    tick1(); chk("R6 12AM->01AM", hour, 8'h41);
  endtask

  task automatic t_months();
    set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h01, 8'h04, 8'h23);
    tick1(); chk("R7 Apr30 mon", mon, 8'h05); chk("R7 Apr30 date", date, 8'h01);
    set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h01, 8'h05, 8'h23);
    tick1(); chk("R7 May30 no wrap", date, 8'h31);
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h01, 8'h02, 8'h23);
    tick1(); chk("R7 Feb28 common", mon, 8'h03); chk("R7 Feb28 date", date, 8'h01);
    set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h01, 8'h12, 8'h99);
    tick1(); chk("R10 year wrap", year, 8'h00); chk("R10 mon wrap", mon, 8'h01);
    chk("R10 date", date, 8'h01);
    set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h01, 8'h12, 8'h47);
    tick1(); chk("R10 year step", year, 8'h48);
  endtask

  task automatic t_leap();
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h01, 8'h02, 8'h24);
    tick1(); chk("R8 24 Feb29", date, 8'h29); chk("R8 24 mon", mon, 8'h02);
    wr(S_HOUR, 8'h23); wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
    tick1(); chk("R8 Feb29 wrap", mon, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h01, 8'h02, 8'h00);
    tick1(); chk("R8 00 leap", date, 8'h29);
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h01, 8'h02, 8'h12);
    tick1(); chk("R8 12 leap", date, 8'h29);
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h01, 8'h02, 8'h10);
    tick1(); chk("R8 10 common", date, 8'h01);
  endtask

  task automatic t_wday();
    set_all(8'h23, 8'h59, 8'h59, 8'h09, 8'h07, 8'h08, 8'h30);
    tick1(); chk("R9 wday wrap", wday, 8'h01);
  endtask

  task automatic t_write();
    set_all(8'h08, 8'h10, 8'h59, 8'h03, 8'h02, 8'h02, 8'h30);
    wr_en = 1'b1; wr_sel = S_YEAR; wr_data = 8'h42; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R11 year written", year, 8'h42);
    chk("R11 tick dropped sec", sec, 8'h59); chk("R11 tick dropped min", min, 8'h10);
    wr(S_SEC, 8'hFF); chk("R11 sec mask", sec, 8'h7F);
    wr(S_HOUR, 8'hFF); chk("R4 hour bit7 zero", hour, 8'h7F);
    wr(S_NONE, 8'h33);
    chk("R11 none sec", sec, 8'h7F); chk("R11 none year", year, 8'h42);
    chk("R11 none date", date, 8'h03);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sec_min();
    t_run_off();
    t_24h();
    t_12h();
    t_months();
    t_leap();
    t_wday();
    t_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule